// File: doc/BRIEF.md
# USB Device Interrupt Status and Enable Unit

This unit gathers the eight device-level event strobes of a USB function controller into one status word, keeps them until software acknowledges them, and raises a single interrupt line whenever a latched event has its enable bit set. It also records which endpoint, and in which direction, produced the most recent completed transfer, so that the interrupt handler can find the source by reading one word.

A second word holds the per-event enable bits together with five plain control bits (resume request, forced suspend, low-power mode, power down, forced bus reset). The unit only stores these control bits; whatever acts on them lives elsewhere. Both words sit on a minimal register port: a one-bit word select, a write strobe, write data and combinational read data. Acknowledging status uses a write-zero-to-clear convention, so software can acknowledge a chosen subset without a read-modify-write race against new events.

Top module: `usb_irq_unit`

## Requirements
- R1: After reset the status word reads 0x0000, the control word reads 0x0001 and `irq_o` is low.
- R2: A high `evt_i[k]` at a rising clock edge sets status bit 8+k, where k=7 is transfer complete, 6 overrun/underrun, 5 error, 4 wakeup, 3 suspend, 2 bus reset, 1 start of frame and 0 missed start of frame; the bit stays set until software clears it.
- R3: A write to the status word (`reg_sel_i`=0) clears each status bit 15:8 whose write-data bit is 0 and leaves each bit whose write-data bit is 1 unchanged.
- R4: When an event strobe and a status write that clears the same bit fall in the same cycle, the bit ends up set.
- R5: Status bit 4 (direction) and bits 3:0 (endpoint number) ignore writes; they load from `ep_dir_i` and `ep_num_i` at every transfer-complete strobe (`evt_i[7]`) and hold their value otherwise.
- R6: A write to the control word (`reg_sel_i`=1) stores write-data bits 15:8 as the enables and bits 4:0 as the control bits; control-word bits 7:5 and status-word bits 7:5 always read 0.
- R7: The control word resets with bit 0 (forced bus reset) at 1 and all other bits at 0.
- R8: `irq_o` is high exactly while some status bit 15:8 is set and the control bit at the same position is set; it follows a change in either word in the same cycle that word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 8 | Event strobes, one cycle each, bit k maps to status bit 8+k |
| ep_num_i | input | 4 | Endpoint number of the transfer completing this cycle |
| ep_dir_i | input | 1 | Direction of the transfer completing this cycle |
| reg_sel_i | input | 1 | Word select: 0 status, 1 control |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data of the selected word |
| irq_o | output | 1 | Interrupt request |

## Verification
The two functions that can land on the same edge are a hardware event setting a status bit and a software acknowledge clearing it. The bench drives a strobe on start of frame in the very cycle it writes an all-zero acknowledge to the status word, and judges the outcome by reading the word back: the strobed bit must survive while every other bit is gone. A second collision writes an acknowledge while a transfer-complete strobe updates the endpoint fields, and the read-back must show the new endpoint number untouched by the write data.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    localparam int unsigned REG_W   = 16;
    localparam int unsigned EVT_N   = 8;
    localparam int unsigned EP_W    = 4;
    localparam int unsigned CTL_N   = 5;
    localparam int unsigned EVT_LSB = REG_W - EVT_N;
    localparam int unsigned GAP_ST  = EVT_LSB - EP_W - 1;
    localparam int unsigned GAP_CT  = EVT_LSB - CTL_N;
    localparam int unsigned XFER_K  = EVT_N - 1;

    typedef enum logic {
        SEL_STAT = 1'b0,
        SEL_CTRL = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/usb_irq_evt_latch.sv
module usb_irq_evt_latch #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         ack_i,
    input  logic [N-1:0] keep_i,
    output logic [N-1:0] pend_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_o[g] <= 1'b0;
            end else if (evt_i[g]) begin
                pend_o[g] <= 1'b1;
            end else if (ack_i && !keep_i[g]) begin
                pend_o[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/usb_irq_ep_tag.sv
module usb_irq_ep_tag #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] num_i,
    input  logic         dir_i,
    output logic [W-1:0] num_o,
    output logic         dir_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            num_o <= '0;
            dir_o <= 1'b0;
        end else if (load_i) begin
            num_o <= num_i;
            dir_o <= dir_i;
        end
    end
endmodule

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl #(
    parameter int unsigned MN = 8,
    parameter int unsigned CN = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [MN-1:0] mask_d,
    input  logic [CN-1:0] ctl_d,
    output logic [MN-1:0] mask_o,
    output logic [CN-1:0] ctl_o
);
    localparam logic [CN-1:0] CTL_RST = CN'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '0;
            ctl_o  <= CTL_RST;
        end else if (wr_i) begin
            mask_o <= mask_d;
            ctl_o  <= ctl_d;
        end
    end
endmodule

// File: rtl/usb_irq_unit.sv
module usb_irq_unit
    import usb_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt_i,
    input  logic [EP_W-1:0]  ep_num_i,
    input  logic             ep_dir_i,
    input  logic             reg_sel_i,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             irq_o
);
    logic [EVT_N-1:0] pend;
    logic [EVT_N-1:0] mask;
    logic [CTL_N-1:0] ctl;
    logic [EP_W-1:0]  tag_num;
    logic             tag_dir;
    logic             stat_ack;
    logic             ctrl_wr;
    logic [REG_W-1:0] stat_word;
    logic [REG_W-1:0] ctrl_word;
    logic             unused_wbits;

    assign stat_ack     = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_STAT);
    assign ctrl_wr      = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_CTRL);
    assign unused_wbits = ^reg_wdata_i[EVT_LSB-1:CTL_N];

    usb_irq_evt_latch #(.N(EVT_N)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .ack_i  (stat_ack),
        .keep_i (reg_wdata_i[REG_W-1:EVT_LSB]),
        .pend_o (pend)
    );

    usb_irq_ep_tag #(.W(EP_W)) u_tag (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (evt_i[XFER_K]),
        .num_i  (ep_num_i),
        .dir_i  (ep_dir_i),
        .num_o  (tag_num),
        .dir_o  (tag_dir)
    );

    usb_irq_ctrl #(.MN(EVT_N), .CN(CTL_N)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (ctrl_wr),
        .mask_d (reg_wdata_i[REG_W-1:EVT_LSB]),
        .ctl_d  (reg_wdata_i[CTL_N-1:0]),
        .mask_o (mask),
        .ctl_o  (ctl)
    );

    assign stat_word = {pend, {GAP_ST{1'b0}}, tag_dir, tag_num};
    assign ctrl_word = {mask, {GAP_CT{1'b0}}, ctl};

    always_comb begin
        unique case (reg_sel_e'(reg_sel_i))
            SEL_STAT: reg_rdata_o = stat_word;
            SEL_CTRL: reg_rdata_o = ctrl_word;
            default:  reg_rdata_o = '0;
        endcase
    end

    assign irq_o = |(pend & mask);
endmodule

// File: rtl/usb_irq_unit_chk.sv
module usb_irq_unit_chk
    import usb_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [EVT_N-1:0] evt_i,
    input logic             reg_sel_i,
    input logic             reg_wr_i,
    input logic [REG_W-1:0] reg_wdata_i,
    input logic [REG_W-1:0] reg_rdata_o,
    input logic [REG_W-1:0] stat_word,
    input logic             irq_o
);
    // R2
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((stat_word[REG_W-1:EVT_LSB] & $past(evt_i)) == $past(evt_i)));

    // R4
    evt_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && !reg_sel_i && evt_i != '0)
        |=> ((stat_word[REG_W-1:EVT_LSB] & $past(evt_i)) == $past(evt_i)));

    // R3
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(reg_wr_i && !reg_sel_i) && evt_i == '0) |=> $stable(stat_word[REG_W-1:EVT_LSB]));

    // R5
    tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_i[XFER_K] |=> $stable(stat_word[EP_W:0]));

    // R8
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_sel_i && reg_wdata_i[REG_W-1:EVT_LSB] == '0) |=> !irq_o);

    // R6
    gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[EVT_LSB-1:CTL_N] == '0);
endmodule

bind usb_irq_unit usb_irq_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .stat_word   (stat_word),
    .irq_o       (irq_o)
);

// File: tb/usb_irq_unit_test.sv
module usb_irq_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_i = '0;
    logic [3:0]  ep_num_i = '0;
    logic        ep_dir_i = 1'b0;
    logic        reg_sel_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    usb_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ep_num_i(ep_num_i),
        .ep_dir_i(ep_dir_i), .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [15:0] val);
        reg_sel_i = sel;
        #1;
        val = reg_rdata_o;
    endtask

    // one cycle with optional write and event, then back to idle at the falling edge
    task automatic cyc(input logic wr, input logic sel, input logic [15:0] wd,
                       input logic [7:0] ev, input logic [3:0] num, input logic dir);
        reg_wr_i = wr; reg_sel_i = sel; reg_wdata_i = wd;
        evt_i = ev; ep_num_i = num; ep_dir_i = dir;
        @(posedge clk);
        @(negedge clk);
        reg_wr_i = 1'b0; evt_i = '0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(1'b0, v); check("R1 status", v, 16'h0000);
        rd(1'b1, v); check("R7 control", v, 16'h0001);
        check("R1 irq", {15'd0, irq_o}, 16'h0000);
    endtask

    task automatic t_events();
        logic [15:0] v;
        logic [15:0] exp = 16'h0000;
        for (int k = 0; k < 7; k++) begin
            cyc(1'b0, 1'b0, 16'h0, 8'(1 << k), 4'h3, 1'b1);
            exp[8+k] = 1'b1;
            rd(1'b0, v); check("R2 event bit", v, exp);
        end
        cyc(1'b0, 1'b0, 16'h0, 8'h80, 4'h5, 1'b1);
        exp = 16'hFF15;
        rd(1'b0, v); check("R2 R5 transfer complete", v, exp);
        check("R8 irq masked", {15'd0, irq_o}, 16'h0000);
    endtask

    task automatic t_control();
        logic [15:0] v;
        cyc(1'b1, 1'b1, 16'hFFFF, 8'h0, 4'h0, 1'b0);
        rd(1'b1, v); check("R6 control write", v, 16'hFF1F);
        cyc(1'b1, 1'b1, 16'h00E0, 8'h0, 4'h0, 1'b0);
        rd(1'b1, v); check("R6 gap bits", v, 16'h0000);
        check("R8 no enables", {15'd0, irq_o}, 16'h0000);
        cyc(1'b1, 1'b1, 16'h8000, 8'h0, 4'h0, 1'b0);
        check("R8 enable transfer", {15'd0, irq_o}, 16'h0001);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        cyc(1'b1, 1'b0, 16'h7FFF, 8'h0, 4'h0, 1'b0);
        rd(1'b0, v); check("R3 R5 selective clear", v, 16'h7F15);
        check("R8 irq drop", {15'd0, irq_o}, 16'h0000);
        cyc(1'b1, 1'b0, 16'hFFFF, 8'h0, 4'h0, 1'b0);
        rd(1'b0, v); check("R3 ones keep", v, 16'h7F15);
        cyc(1'b1, 1'b0, 16'h0000, 8'h0, 4'h0, 1'b0);
        rd(1'b0, v); check("R3 clear all", v, 16'h0015);
    endtask

    task automatic t_collide();
        logic [15:0] v;
        cyc(1'b1, 1'b1, 16'h0200, 8'h0, 4'h0, 1'b0);
        cyc(1'b1, 1'b0, 16'h0000, 8'h02, 4'h0, 1'b0);
        rd(1'b0, v); check("R4 event wins", v, 16'h0215);
        check("R8 sof irq", {15'd0, irq_o}, 16'h0001);
        cyc(1'b1, 1'b0, 16'h0000, 8'h80, 4'hA, 1'b0);
        rd(1'b0, v); check("R4 R5 xfer during ack", v, 16'h800A);
    endtask

    task automatic t_tag();
        logic [15:0] v;
        cyc(1'b0, 1'b0, 16'h0, 8'h40, 4'h7, 1'b1);
        rd(1'b0, v); check("R5 other event keeps tag", v, 16'hC00A);
        cyc(1'b1, 1'b0, 16'hFFE0, 8'h0, 4'h0, 1'b0);
        rd(1'b0, v); check("R5 write ignored", v, 16'hC00A);
        check("R8 masked bits", {15'd0, irq_o}, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_events();
        t_control();
        t_clear();
        t_collide();
        t_tag();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=hung expected=finished");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule